// File: doc/BRIEF.md
# Directory Coherence Controller

This block keeps the coherence directory for a set of memory blocks that several processors share. For every block address it records a three-way status (no copy held, read copies held, one writable copy held) together with a presence bit for each processor. Miss requests arrive one at a time. Each request carries a read or write flag, the requesting processor number and the block address.

For each request the controller looks up the entry and works out the coherence actions. It sends invalidations to every other holder as one mask on a single cycle. When another processor owns the block, it also sends a write-back command to that owner and waits for the owner's acknowledge. It then writes the new entry and grants the block to the requester. The network, the caches and the data storage sit outside this block.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset every entry is in the no-copy state with an all-zero presence vector, so the first request to any block produces no invalidate and no write-back.
- R2: A read of a block with no copy leaves it in the read-shared state with only the requester's presence bit set.
- R3: A read of a read-shared block keeps it shared and adds the requester's bit to the bits already set.
- R4: A write by a processor that is not the owner leaves the block owned by the writer with only its bit set. Every other processor whose bit was set receives an invalidate. inv_valid is high for exactly one cycle, the cycle after acceptance, and inv_mask bit i addresses processor i. No invalidate pulse is issued when the mask would be empty.
- R5: A read of an owned block by another processor raises wb_valid with wb_pid equal to the owner. After the acknowledge the block is shared with exactly the owner's and the requester's bits set. wb_valid and wb_pid hold until wb_ack.
- R6: A write to an owned block by another processor issues a write-back to the old owner and an invalidate of it (bit of the owner in inv_mask). Ownership then passes to the writer alone.
- R7: A read or write by the current owner of an owned block issues no commands and leaves the entry unchanged.
- R8: req_ready is high only while no request is in progress. A request is accepted on a clock edge where req_valid and req_ready are both high.
- R9: grant_valid is high for one cycle with grant_pid equal to the requester. This happens two cycles after acceptance when no write-back is needed, otherwise the cycle after wb_ack is sampled high. The controller is ready again on the next cycle.
- R10: Entries of different block addresses change independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_pid | input | PIDW | Requesting processor number |
| req_addr | input | AW | Block address (directory index) |
| inv_valid | output | 1 | Invalidate pulse |
| inv_mask | output | NPROC | Processors to invalidate, bit i = processor i |
| wb_valid | output | 1 | Write-back command to the owner is pending |
| wb_pid | output | PIDW | Owner that must write back |
| wb_ack | input | 1 | Owner has completed the write-back |
| grant_valid | output | 1 | Block granted to the requester |
| grant_pid | output | PIDW | Processor receiving the grant |

## Verification
A single block address is driven through every transition, with reads and writes from different processors. The invalidate mask seen on a later write reveals which presence bits earlier reads left set, which separates "add a sharer" from "replace the sharers". Owned blocks are hit by the owner and by non-owners for both reads and writes, which separates the write-back-only case, the write-back-plus-invalidate case and the no-action case. A second and a third address are interleaved to show that entries do not disturb each other. Reset in mid-history is followed by writes, which must find clean entries.

// File: rtl/dir_coh_pkg.sv
package dir_coh_pkg;
  typedef enum logic [1:0] {
    BLK_NONE = 2'd0,
    BLK_SHRD = 2'd1,
    BLK_OWND = 2'd2
  } blk_st_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CMD   = 2'd1,
    SEQ_WB    = 2'd2,
    SEQ_GRANT = 2'd3
  } seq_st_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_coh_pkg::*;
#(
  parameter int NPROC = 3,
  parameter int NBLK  = 8,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output blk_st_e          rd_st,
  output logic [NPROC-1:0] rd_vec,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  blk_st_e          wr_st,
  input  logic [NPROC-1:0] wr_vec
);
  blk_st_e          st_q  [NBLK];
  logic [NPROC-1:0] vec_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= BLK_NONE;
        vec_q[g] <= '0;
      end else if (ent_en) begin
        st_q[g]  <= wr_st;
        vec_q[g] <= wr_vec;
      end
    end
  end

  assign rd_st  = st_q[rd_addr];
  assign rd_vec = vec_q[rd_addr];
endmodule

// File: rtl/dir_action.sv
module dir_action
  import dir_coh_pkg::*;
#(
  parameter int NPROC = 3,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  blk_st_e          cur_st,
  input  logic [NPROC-1:0] cur_vec,
  input  logic             req_write,
  input  logic [PIDW-1:0]  req_pid,
  output blk_st_e          nxt_st,
  output logic [NPROC-1:0] nxt_vec,
  output logic [NPROC-1:0] inv_mask,
  output logic             wb_need,
  output logic [PIDW-1:0]  owner_pid
);
  logic [NPROC-1:0] req_bit;
  logic             is_owner;

  always_comb begin
    req_bit   = '0;
    owner_pid = '0;
    for (int i = 0; i < NPROC; i++) begin
      if (req_pid == PIDW'(i)) req_bit[i] = 1'b1;
      if (cur_vec[i])          owner_pid  = PIDW'(i);
    end
  end

  assign is_owner = (cur_st == BLK_OWND) && (owner_pid == req_pid);

  always_comb begin
    nxt_st   = cur_st;
    nxt_vec  = cur_vec;
    inv_mask = '0;
    wb_need  = 1'b0;
    if (!is_owner) begin
      wb_need = (cur_st == BLK_OWND);
      if (req_write) begin
        nxt_st   = BLK_OWND;
        nxt_vec  = req_bit;
        inv_mask = cur_vec & ~req_bit;
      end else begin
        nxt_st  = BLK_SHRD;
        nxt_vec = cur_vec | req_bit;
      end
    end
  end
endmodule

// File: rtl/dir_seq.sv
module dir_seq
  import dir_coh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic wb_need,
  input  logic wb_ack,
  output logic req_ready,
  output logic accept,
  output logic cmd_phase,
  output logic wb_phase,
  output logic grant_phase
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:  if (req_valid) st_d = SEQ_CMD;
      SEQ_CMD:   st_d = (wb_need && !wb_ack) ? SEQ_WB : SEQ_GRANT;
      SEQ_WB:    if (wb_ack) st_d = SEQ_GRANT;
      SEQ_GRANT: st_d = SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready   = (st_q == SEQ_IDLE);
  assign accept      = req_ready && req_valid;
  assign cmd_phase   = (st_q == SEQ_CMD);
  assign wb_phase    = (st_q == SEQ_WB);
  assign grant_phase = (st_q == SEQ_GRANT);
endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl
  import dir_coh_pkg::*;
#(
  parameter int NPROC = 3,
  parameter int NBLK  = 8,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [PIDW-1:0]  req_pid,
  input  logic [AW-1:0]    req_addr,
  output logic             inv_valid,
  output logic [NPROC-1:0] inv_mask,
  output logic             wb_valid,
  output logic [PIDW-1:0]  wb_pid,
  input  logic             wb_ack,
  output logic             grant_valid,
  output logic [PIDW-1:0]  grant_pid
);
  logic             accept, cmd_phase, wb_phase, grant_phase, wb_need;
  logic             wr_q, wr_d;
  logic [PIDW-1:0]  pid_q, pid_d, owner_pid;
  logic [AW-1:0]    addr_q, addr_d;
  blk_st_e          cur_st, nxt_st;
  logic [NPROC-1:0] cur_vec, nxt_vec, kill_mask;

  // request latch: next-state then register
  always_comb begin
    wr_d   = wr_q;
    pid_d  = pid_q;
    addr_d = addr_q;
    if (accept) begin
      wr_d   = req_write;
      pid_d  = req_pid;
      addr_d = req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      pid_q  <= '0;
      addr_q <= '0;
    end else begin
      wr_q   <= wr_d;
      pid_q  <= pid_d;
      addr_q <= addr_d;
    end
  end

  dir_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .wb_need     (wb_need),
    .wb_ack      (wb_ack),
    .req_ready   (req_ready),
    .accept      (accept),
    .cmd_phase   (cmd_phase),
    .wb_phase    (wb_phase),
    .grant_phase (grant_phase)
  );

  dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_q),
    .rd_st   (cur_st),
    .rd_vec  (cur_vec),
    .wr_en   (grant_phase),
    .wr_addr (addr_q),
    .wr_st   (nxt_st),
    .wr_vec  (nxt_vec)
  );

  dir_action #(.NPROC(NPROC)) u_act (
    .cur_st    (cur_st),
    .cur_vec   (cur_vec),
    .req_write (wr_q),
    .req_pid   (pid_q),
    .nxt_st    (nxt_st),
    .nxt_vec   (nxt_vec),
    .inv_mask  (kill_mask),
    .wb_need   (wb_need),
    .owner_pid (owner_pid)
  );

  assign inv_valid   = cmd_phase && (kill_mask != '0);
  assign inv_mask    = inv_valid ? kill_mask : '0;
  assign wb_valid    = (cmd_phase || wb_phase) && wb_need;
  assign wb_pid      = owner_pid;
  assign grant_valid = grant_phase;
  assign grant_pid   = pid_q;
endmodule

// File: rtl/dir_coh_chk.sv
module dir_coh_chk #(
  parameter int NPROC = 3,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             inv_valid,
  input logic [NPROC-1:0] inv_mask,
  input logic             wb_valid,
  input logic [PIDW-1:0]  wb_pid,
  input logic             wb_ack,
  input logic             grant_valid
);
  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid || wb_valid || grant_valid) |-> !req_ready);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  inv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid);

  // R4
  inv_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_mask != '0));

  // R5
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_pid)));

  // R9
  grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ack) |=> grant_valid);

  // R9
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> (!grant_valid && req_ready));
endmodule

bind dir_coh_ctrl dir_coh_chk #(.NPROC(NPROC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .inv_valid   (inv_valid),
  .inv_mask    (inv_mask),
  .wb_valid    (wb_valid),
  .wb_pid      (wb_pid),
  .wb_ack      (wb_ack),
  .grant_valid (grant_valid)
);

// File: tb/dir_coh_ctrl_tb.sv
`timescale 1ns/1ps
module dir_coh_ctrl_tb;
  localparam int NPROC = 3;
  localparam int NBLK  = 8;
  localparam int PIDW  = 2;
  localparam int AW    = 3;
  localparam int NVEC  = 15;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, wb_valid, wb_ack, inv_valid, grant_valid;
  logic [PIDW-1:0]  req_pid, wb_pid, grant_pid;
  logic [AW-1:0]    req_addr;
  logic [NPROC-1:0] inv_mask;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  dir_coh_ctrl #(.NPROC(NPROC), .NBLK(NBLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_pid(req_pid), .req_addr(req_addr),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .wb_valid(wb_valid),
    .wb_pid(wb_pid), .wb_ack(wb_ack), .grant_valid(grant_valid),
    .grant_pid(grant_pid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // fields: write, pid[2], addr[3], inv_mask[3], wb, wb_pid[2]
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 3'd0, 3'b000, 1'b0, 2'd0},  // R2 read p0, none held
    {1'b0, 2'd2, 3'd0, 3'b000, 1'b0, 2'd0},  // R3 read p2, shared
    {1'b1, 2'd0, 3'd0, 3'b100, 1'b0, 2'd0},  // R4 write p0 kills p2 (shows R3 kept p0,p2)
    {1'b0, 2'd1, 3'd0, 3'b000, 1'b1, 2'd0},  // R5 read p1, owner p0
    {1'b1, 2'd2, 3'd0, 3'b011, 1'b0, 2'd0},  // R4 write p2, sharers p0,p1 (R5 result)
    {1'b1, 2'd0, 3'd0, 3'b100, 1'b1, 2'd2},  // R6 write p0, owner p2
    {1'b0, 2'd0, 3'd0, 3'b000, 1'b0, 2'd0},  // R7 owner read
    {1'b1, 2'd0, 3'd0, 3'b000, 1'b0, 2'd0},  // R7 owner write
    {1'b0, 2'd1, 3'd1, 3'b000, 1'b0, 2'd0},  // R10 other block untouched
    {1'b1, 2'd2, 3'd1, 3'b010, 1'b0, 2'd0},  // R10 R2 block 1 held by p1 only
    {1'b1, 2'd1, 3'd0, 3'b001, 1'b1, 2'd0},  // R6 block 0 still owned by p0
    {1'b0, 2'd1, 3'd0, 3'b000, 1'b0, 2'd0},  // R7 new owner read
    {1'b0, 2'd2, 3'd2, 3'b000, 1'b0, 2'd0},  // R2 block 2
    {1'b1, 2'd2, 3'd2, 3'b000, 1'b0, 2'd0},  // R4 sole sharer writes, no pulse
    {1'b1, 2'd0, 3'd2, 3'b100, 1'b1, 2'd2}   // R6 block 2
  };

  // one request; hold_ack delays the write-back acknowledge by one cycle
  task automatic do_req(input logic w, input int pid, input int addr,
                        input int e_inv, input logic e_wb, input int e_wbp,
                        input bit hold_ack);
    @(negedge clk);
    chk("R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = w; req_pid = PIDW'(pid); req_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready low while busy", req_ready, 0);
    chk("R4 inv_valid", inv_valid, (e_inv != 0) ? 1 : 0);
    chk("R4 R6 inv_mask", inv_mask, e_inv);
    chk("R5 R6 wb_valid", wb_valid, e_wb);
    if (e_wb) begin
      chk("R5 R6 wb_pid", wb_pid, e_wbp);
      if (hold_ack) begin
        @(posedge clk); @(negedge clk);
        chk("R5 wb held", wb_valid, 1);
        chk("R5 wb_pid held", wb_pid, e_wbp);
        chk("R4 inv single cycle", inv_valid, 0);
        chk("R9 no grant before ack", grant_valid, 0);
      end
      wb_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      wb_ack = 1'b0;
    end else begin
      @(posedge clk); @(negedge clk);
    end
    chk("R9 grant_valid", grant_valid, 1);
    chk("R9 grant_pid", grant_pid, pid);
    chk("R4 inv single cycle", inv_valid, 0);
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_pid = '0;
    req_addr = '0; wb_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 inv_valid after reset", inv_valid, 0);
    chk("R1 wb_valid after reset", wb_valid, 0);
    chk("R1 grant_valid after reset", grant_valid, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      v = VEC[i];
      do_req(v[11], int'(v[10:9]), int'(v[8:6]), int'(v[5:3]), v[2],
             int'(v[1:0]), (i % 2) == 1);
    end

    // R1: reset in mid-history clears every entry
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_req(1'b1, 1, 0, 3'b000, 1'b0, 0, 1'b0);  // R1 block 0 clean
    do_req(1'b1, 0, 2, 3'b000, 1'b0, 0, 1'b0);  // R1 block 2 clean
    do_req(1'b0, 2, 0, 3'b000, 1'b1, 1, 1'b0);  // R5 owner p1 from above

    // R8: request held while busy is taken only once
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_pid = 2'd0; req_addr = 3'd5;
    @(posedge clk); @(negedge clk);
    chk("R8 ready low after accept", req_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 grant two cycles after accept", grant_valid, 1);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 ready after grant", req_ready, 1);
    do_req(1'b1, 1, 5, 3'b001, 1'b0, 0, 1'b0);   // R3 only p0 holds block 5

    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule